// File: doc/BRIEF.md
# Programmable Interval Timer with Read-Back

This block provides three independent 16-bit down-counting timer channels behind a byte-wide register interface. Software programs a channel by writing a control byte to the control address. The byte chooses the channel, how count bytes are exchanged and the operating mode. Software then writes the starting count one byte at a time to that channel's data address. Each channel drives one output pin. The output either rises once at terminal count, pulses low for one clock at terminal count, or runs as a continuous square wave. All channels count on the single block clock.

Counts can be frozen for a coherent read with a per-channel latch command. A read-back command latches status and/or count for any set of channels with a single control write. When both are latched, the status byte comes out before the count bytes. A separate side register gates channel 2 and masks its output onto a speaker pin, and it reports the live channel 2 output.

Top module: `pit_timer`

## Requirements
- R1: After reset all timer outputs and the speaker output are 0, the side register reads 0x00 and a read of any counter data address returns 0x00.
- R2: A write to address 3 with bits 7:6 not equal to 11 and bits 5:4 not 00 programs the channel given by bits 7:6. It stores access type bits 5:4 and mode bits 3:1. Mode 3 or 7 selects square wave, mode 4 selects strobe and any other value selects terminal-count. The output goes to 0 for terminal-count and to 1 for the other two modes.
- R3: Access 01 writes the count low byte and clears the high byte. Access 10 writes the high byte and clears the low byte. Access 11 takes the low byte then the high byte. On the clock edge after the final byte, the count moves into the counting element, and decrementing starts on the edge after that. Reads follow the same byte selection.
- R4: In terminal-count mode with count N, the output rises at the (N+1)th clock edge after the final count byte is written, and it then stays high. Completing a new count write drives it back to 0 and restarts the sequence.
- R5: In strobe mode the output is high and goes low for exactly one clock at the (N+1)th edge after the final count byte. This happens once per loaded count.
- R6: In square-wave mode the output is high for ceil(N/2) clocks and low for floor(N/2) clocks, repeating without further writes. The counting element steps by two and always holds an even value.
- R7: A control byte with bits 5:4 = 00 latches the channel's current count. Reads then return the frozen low byte followed by the high byte (access 11). Further latch requests are ignored until the latched value has been fully read.
- R8: A control byte with bits 7:6 = 11 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 latches the count and bit 4 = 0 latches the status. Several channels can be selected at once. A latched status byte is read before any latched count bytes.
- R9: The status byte is: bit 7 the output level, bit 6 a pending-count flag, bits 5:4 the access type, bits 3:1 the mode, and bit 0 zero. The pending-count flag is set by a control write or a completed count write and cleared when the count is transferred.
- R10: Side register bit 0 gates channel 2, and while it is 0 channel 2 holds its count. A transfer still happens while the gate is 0. Bit 1 enables the speaker output, which equals channel 2's output AND bit 1. The register reads back bits 1:0 as written and bit 4 as the live channel 2 output. Channels 0 and 1 always count.
- R11: With nothing latched, reads return the live count. Under access 11 they alternate low byte then high byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block and counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe, advances the read byte sequence |
| addr | input | 2 | Register address: 0-2 counter data, 3 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed counter |
| side_wr | input | 1 | Side register write strobe |
| side_wdata | input | 8 | Side register write data |
| side_rdata | output | 8 | Side register read value |
| tmr_out | output | 3 | Channel outputs |
| spk_out | output | 1 | Channel 2 output masked by speaker enable |

## Verification
Some properties are checked on every clock cycle. A terminal-count output stays high once it has risen, a strobe pulse lasts one clock, and a latched value holds until it is read or the channel is reprogrammed. A transfer always starts the count and clears the pending flag, and the square-wave counting element stays even. The bench scenarios cover what depends on counted sequences. These include the exact edge at which each mode's output changes, ignored second latch requests and the status-before-count order across several channels. They also cover byte-access variants, and gated counting and masking on channel 2.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int CE_W   = CNT_W + 1;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_BOTH  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    K_TERM   = 2'd0,
    K_SQUARE = 2'd1,
    K_STROBE = 2'd2
  } kind_e;

  function automatic kind_e mode_kind(input logic [2:0] m);
    case (m)
      3'd3, 3'd7: return K_SQUARE;
      3'd4:       return K_STROBE;
      default:    return K_TERM;
    endcase
  endfunction

  // Length in clocks*2 of one square-wave phase; odd counts stretch the high phase.
  function automatic logic [CE_W-1:0] sq_phase_len(input logic [CNT_W-1:0] n, input logic high);
    logic [CE_W-1:0] full;
    logic [CE_W-1:0] len;
    full = (n == '0) ? (CE_W'(1) << CNT_W) : {1'b0, n};
    if (high) len = full + {{(CE_W-1){1'b0}}, full[0]};
    else      len = full - {{(CE_W-1){1'b0}}, full[0]};
    if (len < CE_W'(2)) len = CE_W'(2);
    return len;
  endfunction

  function automatic logic [BYTE_W-1:0] status_byte(input logic o, input logic pend,
                                                    input acc_e acc, input logic [2:0] m);
    return {o, pend, acc, m, 1'b0};
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [CNT_W-1:0] v, input acc_e acc,
                                                  input logic hi);
    case (acc)
      ACC_HI:   return v[CNT_W-1:BYTE_W];
      ACC_BOTH: return hi ? v[CNT_W-1:BYTE_W] : v[BYTE_W-1:0];
      default:  return v[BYTE_W-1:0];
    endcase
  endfunction
endpackage

// File: rtl/pit_decode.sv
`timescale 1ns/1ps
module pit_decode #(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [6:0]        wbits,      // write data bits 7:1
  output logic [NUM_CH-1:0] cw_wr,
  output logic [NUM_CH-1:0] cnt_latch,
  output logic [NUM_CH-1:0] st_latch,
  output logic [NUM_CH-1:0] cnt_wr,
  output logic [NUM_CH-1:0] rd_ack
);
  logic       ctrl_hit;
  logic       is_readback;
  logic [1:0] sel_ch;
  logic [1:0] acc_f;
  logic       rb_no_cnt;
  logic       rb_no_st;

  assign ctrl_hit    = wr_en && (addr == ADDR_W'(NUM_CH));
  assign sel_ch      = wbits[6:5];
  assign acc_f       = wbits[4:3];
  assign is_readback = (sel_ch == 2'b11);
  assign rb_no_cnt   = wbits[4];
  assign rb_no_st    = wbits[3];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic picked;
    logic rb_pick;
    assign picked       = !is_readback && (sel_ch == 2'(g));
    assign rb_pick      = is_readback && wbits[g];
    assign cw_wr[g]     = ctrl_hit && picked && (acc_f != 2'b00);
    assign cnt_latch[g] = ctrl_hit && ((picked && acc_f == 2'b00) || (rb_pick && !rb_no_cnt));
    assign st_latch[g]  = ctrl_hit && rb_pick && !rb_no_st;
    assign cnt_wr[g]    = wr_en && (addr == ADDR_W'(g));
    assign rd_ack[g]    = rd_en && (addr == ADDR_W'(g));
  end
endmodule

// File: rtl/pit_channel.sv
`timescale 1ns/1ps
module pit_channel
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate,
  input  logic              cw_wr,
  input  logic              cnt_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              cnt_latch_req,
  input  logic              st_latch_req,
  input  logic              rd_ack,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              out
);
  logic [2:0]       mode_q;
  acc_e             acc_q;
  logic [CNT_W-1:0] cr_q;
  logic [CE_W-1:0]  ce_q;
  logic             out_q, null_q, pend_q, run_q;
  logic             wr_hi_q, rd_hi_q, strobe_done_q;
  logic             cl_q, sl_q;
  logic [CNT_W-1:0] cl_val;
  logic [BYTE_W-1:0] sl_val;

  // Named internal events
  kind_e            kind;
  logic             count_en;
  logic             write_done;
  logic             tc_evt;
  logic             sq_flip;
  logic             strobe_fire;
  logic             latch_take;
  logic [BYTE_W-1:0] status_now;

  assign kind        = mode_kind(mode_q);
  assign count_en    = run_q && gate && !pend_q;
  assign write_done  = cnt_wr && (acc_q == ACC_LO || acc_q == ACC_HI ||
                                  (acc_q == ACC_BOTH && wr_hi_q));
  assign tc_evt      = count_en && (kind != K_SQUARE) && (ce_q[CNT_W-1:0] == CNT_W'(1));
  assign sq_flip     = count_en && (kind == K_SQUARE) && (ce_q <= CE_W'(2));
  assign strobe_fire = tc_evt && (kind == K_STROBE) && !strobe_done_q;
  assign latch_take  = cnt_latch_req && !cl_q;
  assign status_now  = status_byte(out_q, null_q, acc_q, mode_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q        <= '0;
      acc_q         <= ACC_LATCH;
      cr_q          <= '0;
      ce_q          <= '0;
      out_q         <= 1'b0;
      null_q        <= 1'b0;
      pend_q        <= 1'b0;
      run_q         <= 1'b0;
      wr_hi_q       <= 1'b0;
      rd_hi_q       <= 1'b0;
      strobe_done_q <= 1'b0;
      cl_q          <= 1'b0;
      sl_q          <= 1'b0;
      cl_val        <= '0;
      sl_val        <= '0;
    end else if (cw_wr) begin
      mode_q        <= wdata[3:1];
      acc_q         <= acc_e'(wdata[5:4]);
      out_q         <= (mode_kind(wdata[3:1]) != K_TERM);
      null_q        <= 1'b1;
      pend_q        <= 1'b0;
      run_q         <= 1'b0;
      wr_hi_q       <= 1'b0;
      rd_hi_q       <= 1'b0;
      strobe_done_q <= 1'b0;
      cl_q          <= 1'b0;
      sl_q          <= 1'b0;
    end else begin
      // count byte sequencing
      if (cnt_wr) begin
        case (acc_q)
          ACC_LO: cr_q <= {{BYTE_W{1'b0}}, wdata};
          ACC_HI: cr_q <= {wdata, {BYTE_W{1'b0}}};
          ACC_BOTH: begin
            if (wr_hi_q) cr_q[CNT_W-1:BYTE_W] <= wdata;
            else         cr_q[BYTE_W-1:0]     <= wdata;
            wr_hi_q <= !wr_hi_q;
          end
          default: ;
        endcase
      end
      // end of a strobe pulse
      if (kind == K_STROBE && !out_q) out_q <= 1'b1;
      // transfer or count
      if (pend_q) begin
        pend_q        <= 1'b0;
        run_q         <= 1'b1;
        null_q        <= 1'b0;
        strobe_done_q <= 1'b0;
        if (kind == K_SQUARE) begin
          ce_q  <= sq_phase_len(cr_q, 1'b1);
          out_q <= 1'b1;
        end else begin
          ce_q <= {1'b0, cr_q};
        end
      end else if (count_en) begin
        if (kind == K_SQUARE) begin
          if (sq_flip) begin
            out_q <= !out_q;
            ce_q  <= sq_phase_len(cr_q, !out_q);
          end else begin
            ce_q <= ce_q - CE_W'(2);
          end
        end else begin
          ce_q <= {1'b0, ce_q[CNT_W-1:0] - CNT_W'(1)};
          if (strobe_fire) begin
            out_q         <= 1'b0;
            strobe_done_q <= 1'b1;
          end else if (tc_evt && kind == K_TERM) begin
            out_q <= 1'b1;
          end
        end
      end
      if (write_done) begin
        pend_q <= 1'b1;
        null_q <= 1'b1;
        if (kind == K_TERM) out_q <= 1'b0;
      end
      // read sequencing
      if (rd_ack) begin
        if (sl_q) begin
          sl_q <= 1'b0;
        end else begin
          if (acc_q == ACC_BOTH) rd_hi_q <= !rd_hi_q;
          if (cl_q && (acc_q != ACC_BOTH || rd_hi_q)) cl_q <= 1'b0;
        end
      end
      // latching
      if (latch_take) begin
        cl_q    <= 1'b1;
        cl_val  <= ce_q[CNT_W-1:0];
        rd_hi_q <= 1'b0;
      end
      if (st_latch_req && !sl_q) begin
        sl_q   <= 1'b1;
        sl_val <= status_now;
      end
    end
  end

  always_comb begin
    if (sl_q)      rd_byte = sl_val;
    else if (cl_q) rd_byte = pick_byte(cl_val, acc_q, rd_hi_q);
    else           rd_byte = pick_byte(ce_q[CNT_W-1:0], acc_q, rd_hi_q);
  end

  assign out = out_q;

  // R4: terminal-count output holds high until reprogrammed or reloaded
  a_r4_term_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_TERM && out_q && !cw_wr && !write_done) |=> out_q);

  // R5: strobe low pulse lasts a single clock
  a_r5_strobe_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_STROBE && !out_q && !cw_wr) |=> out_q);

  // R7: a latched count stays frozen until it is read out
  a_r7_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_q && !cw_wr && !rd_ack) |=> (cl_q && $stable(cl_val)));

  // R3 / R9: a transfer starts counting and clears the pending flag
  a_r3_transfer_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !cw_wr && !write_done) |=> (run_q && !null_q));

  // R6: square-wave counting element stays even
  a_r6_square_even: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_SQUARE && run_q) |-> !ce_q[0]);
endmodule

// File: rtl/pit_timer.sv
`timescale 1ns/1ps
module pit_timer
  import pit_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int GATED_CH = 2,
  parameter int ADDR_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              side_wr,
  input  logic [7:0]        side_wdata,
  output logic [7:0]        side_rdata,
  output logic [NUM_CH-1:0] tmr_out,
  output logic              spk_out
);
  logic [NUM_CH-1:0] cw_wr, cnt_latch, st_latch, cnt_wr, rd_ack, gate;
  logic [BYTE_W-1:0] rd_bytes [NUM_CH];
  logic [1:0]        side_q;
  logic              unused_side;

  assign unused_side = ^side_wdata[7:2];

  pit_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wbits     (wdata[7:1]),
    .cw_wr     (cw_wr),
    .cnt_latch (cnt_latch),
    .st_latch  (st_latch),
    .cnt_wr    (cnt_wr),
    .rd_ack    (rd_ack)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       side_q <= '0;
    else if (side_wr) side_q <= side_wdata[1:0];
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    if (g == GATED_CH) begin : g_gated
      assign gate[g] = side_q[0];
    end else begin : g_free
      assign gate[g] = 1'b1;
    end
    pit_channel u_ch (
      .clk           (clk),
      .rst_n         (rst_n),
      .gate          (gate[g]),
      .cw_wr         (cw_wr[g]),
      .cnt_wr        (cnt_wr[g]),
      .wdata         (wdata),
      .cnt_latch_req (cnt_latch[g]),
      .st_latch_req  (st_latch[g]),
      .rd_ack        (rd_ack[g]),
      .rd_byte       (rd_bytes[g]),
      .out           (tmr_out[g])
    );
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(i)) rdata = rd_bytes[i];
    end
  end

  assign spk_out    = tmr_out[GATED_CH] & side_q[1];
  assign side_rdata = {3'b000, tmr_out[GATED_CH], 2'b00, side_q};
endmodule

// File: tb/pit_timer_test.sv
`timescale 1ns/1ps
module pit_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, side_wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, side_wdata = '0;
  logic [7:0] rdata, side_rdata;
  logic [2:0] tmr_out;
  logic       spk_out;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  typedef struct { logic [7:0] exp; string tag; } sb_t;
  sb_t sb[$];

  always #2 clk = ~clk;   // 250 MHz

  pit_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .side_wr(side_wr), .side_wdata(side_wdata),
    .side_rdata(side_rdata), .tmr_out(tmr_out), .spk_out(spk_out)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic sw(input logic [7:0] d);
    side_wr = 1'b1; side_wdata = d;
    @(posedge clk); #1;
    side_wr = 1'b0;
  endtask

  // driver: pushes the expected byte, monitor compares it
  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    sb_t it;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rd_en && sb.size() > 0) begin
      sb_t it;
      it = sb.pop_front();
      chk(rdata, it.exp, it.tag);
    end
  end

  function automatic logic sq_expect(input int n, input int k);
    return ((k - 1) % n) < ((n + 1) / 2);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk({5'd0, tmr_out}, 8'h00, "R1 outputs");
    chk({7'd0, spk_out}, 8'h00, "R1 speaker");
    chk(side_rdata, 8'h00, "R1 side register");
    rd(2'd0, 8'h00, "R1 data read");

    // R2 / R4 / R9: channel 0 terminal-count
    wr(2'd3, 8'h30);
    chk({7'd0, tmr_out[0]}, 8'h00, "R2 mode0 out low");
    wr(2'd3, 8'hE2);
    rd(2'd0, 8'h70, "R9 status pending");
    wr(2'd0, 8'h05); wr(2'd0, 8'h00);
    tick(5); chk({7'd0, tmr_out[0]}, 8'h00, "R4 before terminal");
    tick(1); chk({7'd0, tmr_out[0]}, 8'h01, "R4 at terminal");
    tick(3); chk({7'd0, tmr_out[0]}, 8'h01, "R4 stays high");
    wr(2'd3, 8'hE2);
    rd(2'd0, 8'hB0, "R9 status loaded");
    wr(2'd0, 8'h03); wr(2'd0, 8'h00);
    chk({7'd0, tmr_out[0]}, 8'h00, "R4 restart low");
    tick(3); chk({7'd0, tmr_out[0]}, 8'h00, "R4 restart before");
    tick(1); chk({7'd0, tmr_out[0]}, 8'h01, "R4 restart terminal");

    // R7 / R8: channel 1 latching
    wr(2'd3, 8'h70);
    wr(2'd1, 8'h34); wr(2'd1, 8'h12);
    tick(2);
    wr(2'd3, 8'h40);
    wr(2'd3, 8'h40);          // ignored: still latched
    tick(5);
    rd(2'd1, 8'h33, "R7 latched low");
    rd(2'd1, 8'h12, "R7 latched high");
    wr(2'd3, 8'h40);
    rd(2'd1, 8'h2A, "R7 relatch low");
    rd(2'd1, 8'h12, "R7 relatch high");
    wr(2'd3, 8'hC4);
    rd(2'd1, 8'h30, "R8 status first");
    rd(2'd1, 8'h27, "R8 count low");
    rd(2'd1, 8'h12, "R8 count high");

    // R10 / R11: channel 2 gated
    sw(8'h00);
    wr(2'd3, 8'hB0);
    wr(2'd2, 8'h10); wr(2'd2, 8'h00);
    tick(3);
    rd(2'd2, 8'h10, "R11 live low");
    rd(2'd2, 8'h00, "R11 live high");
    sw(8'h01);
    tick(3);
    sw(8'h00);
    rd(2'd2, 8'h0C, "R10 gated count low");
    rd(2'd2, 8'h00, "R10 gated count high");
    chk(side_rdata, 8'h00, "R10 side readback off");
    sw(8'h03);
    tick(11);
    chk({6'd0, spk_out, tmr_out[2]}, 8'h00, "R10 before terminal");
    tick(1);
    chk({6'd0, spk_out, tmr_out[2]}, 8'h03, "R10 terminal and speaker");
    chk(side_rdata, 8'h13, "R10 side shows output");
    sw(8'h01);
    chk({7'd0, spk_out}, 8'h00, "R10 speaker masked");
    chk(side_rdata, 8'h11, "R10 side masked readback");

    // R8 multi-channel status
    wr(2'd3, 8'hEC);
    rd(2'd1, 8'h30, "R8 multi ch1 status");
    rd(2'd2, 8'hB0, "R8 multi ch2 status");

    // R3 byte access variants
    wr(2'd3, 8'h50);
    wr(2'd1, 8'h07);
    tick(7); chk({7'd0, tmr_out[1]}, 8'h00, "R3 low-only before");
    tick(1); chk({7'd0, tmr_out[1]}, 8'h01, "R3 low-only terminal");
    sw(8'h00);
    wr(2'd3, 8'hA0);
    wr(2'd2, 8'h02);
    tick(2);
    rd(2'd2, 8'h02, "R3 high-only read");
    rd(2'd2, 8'h02, "R3 high-only read again");
    wr(2'd3, 8'h80);
    rd(2'd2, 8'h02, "R7 latch high-only");
    wr(2'd3, 8'hE8);
    rd(2'd2, 8'h20, "R9 status access high");

    // R5 strobe
    wr(2'd3, 8'h38);
    chk({7'd0, tmr_out[0]}, 8'h01, "R2 strobe out high");
    wr(2'd0, 8'h04); wr(2'd0, 8'h00);
    tick(4); chk({7'd0, tmr_out[0]}, 8'h01, "R5 before strobe");
    tick(1); chk({7'd0, tmr_out[0]}, 8'h00, "R5 strobe low");
    tick(1); chk({7'd0, tmr_out[0]}, 8'h01, "R5 strobe ends");
    tick(10); chk({7'd0, tmr_out[0]}, 8'h01, "R5 single strobe");

    // R6 square wave, odd then even
    wr(2'd3, 8'h36);
    wr(2'd0, 8'h05); wr(2'd0, 8'h00);
    for (int k = 1; k <= 10; k++) begin
      tick(1);
      chk({7'd0, tmr_out[0]}, {7'd0, sq_expect(5, k)}, "R6 square N=5");
    end
    wr(2'd0, 8'h04); wr(2'd0, 8'h00);
    for (int k = 1; k <= 8; k++) begin
      tick(1);
      chk({7'd0, tmr_out[0]}, {7'd0, sq_expect(4, k)}, "R6 square N=4");
    end

    tick(2);
    while (sb.size() > 0) tick(1);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule